// File: doc/BRIEF.md
# Eight-Function ALU with Shared Carry/Borrow

This block is an N-bit arithmetic and logic unit with eight operations, chosen by a 3-bit select. There are two operands, `in_a` and `in_b`. One input pin, `in_cb`, serves as both carry-in and borrow-in. One output pin, `out_cb`, serves as both carry-out and borrow-out. The operations are:

- addition with carry;
- subtraction with borrow;
- increment with carry;
- bitwise AND;
- bitwise OR;
- inversion of B;
- pass A;
- equality compare.

Subtraction has no subtractor of its own. It runs on the same ripple-carry adder: B is inverted and the incoming borrow is inverted, then fed in as the carry. The borrow-out is the inverse of the adder's carry-out.

Operations enter as a valid/ready stream and leave as a valid/ready stream, through one output register.

- An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or is being drained in that same cycle. The block can therefore sustain one operation per cycle when `out_ready` stays high.
- While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new operation is accepted. Back-pressure reaches the producer in the same cycle.

Top module: `cb_alu`

## Requirements
- R1: Select 3'b000 (add): `out_result` is `in_a + in_b + in_cb` modulo 2^W, and `out_cb` is the carry out of bit W-1.
- R2: Select 3'b100 (subtract): `out_result` is `in_a - in_b - in_cb` modulo 2^W, and `out_cb` is 1 exactly when `in_a < in_b + in_cb` (borrow out).
- R3: Select 3'b111 (increment): `out_result` is `in_a + 1 + in_cb` modulo 2^W, and `out_cb` is the carry out of that sum.
- R4: Select 3'b001 gives `in_a & in_b` and select 3'b010 gives `in_a | in_b`; both drive `out_cb` to 0 whatever `in_cb` is.
- R5: Select 3'b011 gives `~in_b` with `out_cb` 0; `in_a` and `in_cb` have no effect on the result.
- R6: Select 3'b101 gives `in_a` unchanged with `out_cb` 0; `in_b` and `in_cb` have no effect on the result.
- R7: Select 3'b110 (compare) sets result bit 0 to 1 when `in_a == in_b` and to 0 otherwise; all other result bits and `out_cb` are 0.
- R8: The result of an operation accepted on one rising edge appears on the outputs, with `out_valid` high, after that same edge (one cycle of latency).
- R9: `in_ready` is high whenever `out_valid` is low or `out_ready` is high.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result` and `out_cb` keep their values on the next edge.
- R11: While `rst_n` is low and after it is released, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request present |
| in_ready | output | 1 | Block can take an operation this cycle |
| in_op | input | 3 | Function select (encodings in R1–R7) |
| in_a | input | W | Operand A |
| in_b | input | W | Operand B |
| in_cb | input | 1 | Shared carry-in / borrow-in |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | W | Operation result |
| out_cb | output | 1 | Shared carry-out / borrow-out |

## Verification
The bench targets the carry and borrow edges:

- Additions and increments that wrap at all-ones. A design that dropped the carry-in would be off by one there.
- Subtractions where A equals B with a borrow pending. A design with the borrow polarity wrong would report no borrow, or a result one too high.
- Compares of equal operands and of operands that differ in a single bit. A wrong compare would set the flag, or spill into the upper bits.
- The inputs that R5 and R6 say are ignored are varied while the result is watched.

Back-pressure stalls are checked for a held result and a lost or repeated operation, which would show up as a scoreboard mismatch.

// File: rtl/cb_alu_pkg.sv
package cb_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_AND  = 3'b001,
    OP_OR   = 3'b010,
    OP_NOTB = 3'b011,
    OP_SUB  = 3'b100,
    OP_PASS = 3'b101,
    OP_EQ   = 3'b110,
    OP_INC  = 3'b111
  } alu_op_e;

  function automatic logic uses_adder(input alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC);
  endfunction

endpackage

// File: rtl/cb_alu_adder.sv
module cb_alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] add_x,
  input  logic [W-1:0] add_y,
  input  logic         add_cin,
  output logic [W-1:0] add_sum,
  output logic         add_cout
);

  logic [W:0] chain;

  assign chain[0] = add_cin;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_fa
      logic prop;
      logic gen;
      assign prop         = add_x[gi] ^ add_y[gi];
      assign gen          = add_x[gi] & add_y[gi];
      assign add_sum[gi]  = prop ^ chain[gi];
      assign chain[gi+1]  = gen | (prop & chain[gi]);
    end
  endgenerate

  assign add_cout = chain[W];

endmodule

// File: rtl/cb_alu_logic.sv
module cb_alu_logic
  import cb_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      lg_op,
  input  logic [W-1:0] lg_a,
  input  logic [W-1:0] lg_b,
  output logic [W-1:0] lg_res
);

  localparam int PADW = W - 1;

  logic [W-1:0] diff_bits;
  logic         same;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_cmp
      assign diff_bits[gi] = lg_a[gi] ^ lg_b[gi];
    end
  endgenerate

  assign same = ~|diff_bits;

  always_comb begin
    case (lg_op)
      OP_AND:  lg_res = lg_a & lg_b;
      OP_OR:   lg_res = lg_a | lg_b;
      OP_NOTB: lg_res = ~lg_b;
      OP_PASS: lg_res = lg_a;
      OP_EQ:   lg_res = {{PADW{1'b0}}, same};
      default: lg_res = '0;
    endcase
  end

endmodule

// File: rtl/cb_alu_core.sv
module cb_alu_core
  import cb_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      c_op,
  input  logic [W-1:0] c_a,
  input  logic [W-1:0] c_b,
  input  logic         c_cb_in,
  output logic [W-1:0] c_res,
  output logic         c_cb_out
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] y_sel;
  logic         cin_sel;
  logic [W-1:0] sum;
  logic         cout;
  logic [W-1:0] lres;

  // Operand steering: subtraction reuses the adder through inversion.
  always_comb begin
    y_sel   = c_b;
    cin_sel = c_cb_in;
    case (c_op)
      OP_SUB: begin
        y_sel   = ~c_b;
        cin_sel = ~c_cb_in;
      end
      OP_INC: begin
        y_sel   = ONE;
        cin_sel = c_cb_in;
      end
      default: begin
        y_sel   = c_b;
        cin_sel = c_cb_in;
      end
    endcase
  end

  cb_alu_adder #(.W(W)) u_adder (
    .add_x   (c_a),
    .add_y   (y_sel),
    .add_cin (cin_sel),
    .add_sum (sum),
    .add_cout(cout)
  );

  cb_alu_logic #(.W(W)) u_logic (
    .lg_op (c_op),
    .lg_a  (c_a),
    .lg_b  (c_b),
    .lg_res(lres)
  );

  always_comb begin
    c_res    = uses_adder(c_op) ? sum : lres;
    c_cb_out = 1'b0;
    if (c_op == OP_SUB)
      c_cb_out = ~cout;
    else if (uses_adder(c_op))
      c_cb_out = cout;
  end

endmodule

// File: rtl/cb_alu.sv
module cb_alu
  import cb_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [2:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         in_cb,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_cb
);

  logic [W-1:0] nxt_res;
  logic         nxt_cb;
  logic         take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  cb_alu_core #(.W(W)) u_core (
    .c_op    (alu_op_e'(in_op)),
    .c_a     (in_a),
    .c_b     (in_b),
    .c_cb_in (in_cb),
    .c_res   (nxt_res),
    .c_cb_out(nxt_cb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_cb     <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        out_result <= nxt_res;
        out_cb     <= nxt_cb;
      end
    end
  end

  AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == 3'b000 |=> {out_cb, out_result} ==
      $past({1'b0, in_a} + {1'b0, in_b} + {{W{1'b0}}, in_cb})); // R1

  AST_SUB_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == 3'b100 |=> {out_cb, out_result} ==
      $past({1'b0, in_a} - {1'b0, in_b} - {{W{1'b0}}, in_cb})); // R2

  AST_LOGIC_NO_CB: assert property (@(posedge clk) disable iff (!rst_n)
    take && (in_op == 3'b001 || in_op == 3'b010 || in_op == 3'b011) |=> !out_cb); // R4

  AST_PASS_A: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == 3'b101 |=> out_result == $past(in_a) && !out_cb); // R6

  AST_EQ_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == 3'b110 |=> (out_result >> 1) == '0 && !out_cb
      && out_result[0] == $past(in_a == in_b)); // R7

  AST_ACCEPT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R8

  AST_READY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_cb)); // R10

endmodule

// File: tb/cb_alu_bench.sv
module cb_alu_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [2:0]   in_op = 3'b000;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         in_cb = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_result;
  logic         out_cb;

  int checks = 0;
  int fails  = 0;
  int rdy_mode = 0;
  int popped = 0;
  int pushed = 0;
  logic [W:0] exp_q[$];
  logic [15:0] lfsr = 16'hACE1;
  logic [2:0] op_q[$];

  always #5 clk = ~clk;

  cb_alu #(.W(W)) u_cb_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_cb(in_cb),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_cb(out_cb)
  );

  function automatic logic [W:0] model(input logic [2:0] op, input logic [W-1:0] a,
                                       input logic [W-1:0] b, input logic c);
    logic [W:0] r;
    case (op)
      3'b000: r = {1'b0, a} + {1'b0, b} + (W+1)'(c);
      3'b001: r = {1'b0, a & b};
      3'b010: r = {1'b0, a | b};
      3'b011: r = {1'b0, ~b};
      3'b100: r = {1'b0, a} - {1'b0, b} - (W+1)'(c);
      3'b101: r = {1'b0, a};
      3'b110: r = (W+1)'(a == b);
      default: r = {1'b0, a} + (W+1)'(1) + (W+1)'(c);
    endcase
    return r;
  endfunction

  function automatic string tag(input logic [2:0] op);
    case (op)
      3'b000: return "R1";
      3'b100: return "R2";
      3'b111: return "R3";
      3'b001, 3'b010: return "R4";
      3'b011: return "R5";
      3'b101: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Output consumer pacing
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = lfsr[3];
      default: out_ready = 1'b0;
    endcase
  end

  // Scoreboard monitor: samples one time unit after the falling edge
  logic         prev_stall = 1'b0;
  logic [W:0]   prev_out = '0;
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && {out_cb, out_result} == prev_out, "R10",
              {out_cb, out_result}, prev_out);
      check(in_ready == (!out_valid || out_ready), "R9",
            (W+1)'(in_ready), (W+1)'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", {out_cb, out_result}, '0);
        end else begin
          logic [W:0] e;
          logic [2:0] o;
          e = exp_q.pop_front();
          o = op_q.pop_front();
          popped++;
          check({out_cb, out_result} == e, tag(o), {out_cb, out_result}, e);
        end
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(model(in_op, in_a, in_b, in_cb));
        op_q.push_back(in_op);
        pushed++;
      end
      prev_stall = out_valid && !out_ready;
      prev_out   = {out_cb, out_result};
    end
  end

  // Driver: called at a falling edge, returns at the falling edge after acceptance
  task automatic send(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    bit ok;
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_cb = c;
    forever begin
      #2 ok = in_ready;
      @(negedge clk);
      if (ok) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    rdy_mode = 0;
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
  endtask

  bit done = 0;

  initial begin
    #(2_000_000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check(!out_valid && in_ready, "R11", {out_valid, in_ready}, 2'b01);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check(!out_valid && in_ready, "R11", {out_valid, in_ready}, 2'b01);
    @(negedge clk);

    // R1 add corners
    send(3'b000, 8'hFF, 8'h00, 1'b1);
    send(3'b000, 8'hFF, 8'hFF, 1'b1);
    send(3'b000, 8'h7F, 8'h01, 1'b0);
    // R2 subtract corners
    send(3'b100, 8'h55, 8'h55, 1'b1);
    send(3'b100, 8'h55, 8'h55, 1'b0);
    send(3'b100, 8'h00, 8'hFF, 1'b0);
    send(3'b100, 8'h80, 8'h01, 1'b1);
    // R3 increment corners
    send(3'b111, 8'hFF, 8'h12, 1'b0);
    send(3'b111, 8'hFE, 8'h00, 1'b1);
    send(3'b111, 8'hFF, 8'h00, 1'b1);
    // R4 logic with carry-in set
    send(3'b001, 8'hF0, 8'h3C, 1'b1);
    send(3'b010, 8'hF0, 8'h3C, 1'b1);
    // R5 inversion, A and carry varied
    send(3'b011, 8'h00, 8'hA5, 1'b0);
    send(3'b011, 8'hFF, 8'hA5, 1'b1);
    // R6 pass, B and carry varied
    send(3'b101, 8'h3A, 8'h00, 1'b0);
    send(3'b101, 8'h3A, 8'hFF, 1'b1);
    // R7 compare
    send(3'b110, 8'h9C, 8'h9C, 1'b1);
    send(3'b110, 8'h9C, 8'h9D, 1'b0);
    send(3'b110, 8'h00, 8'h80, 1'b1);
    drain();

    // R10 stall: hold output with consumer blocked
    rdy_mode = 2;
    @(negedge clk);
    send(3'b000, 8'h12, 8'h34, 1'b1);
    in_valid = 1'b1; in_op = 3'b101; in_a = 8'h77; in_b = 8'h00; in_cb = 1'b0;
    repeat (4) @(negedge clk);
    #2 check(!in_ready, "R9", (W+1)'(in_ready), '0);
    in_valid = 1'b0;
    drain();

    // Random traffic under random back-pressure (R8 latency via ordering)
    rdy_mode = 1;
    for (int i = 0; i < 400; i++)
      send(3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom), 1'($urandom));
    drain();

    check(exp_q.size() == 0 && pushed == popped, "R8",
          (W+1)'(exp_q.size()), '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule